// File: doc/BRIEF.md
# Streaming Complex Multiplier with Width Reduction

This block multiplies two streams of signed complex samples. Each stream comes in on its own AXI4-Stream slave port. The complex product leaves on one AXI4-Stream master port. A pair of samples is taken in only when both inputs offer data in the same clock cycle.

The multiplication is carried out at full precision. The result is then fitted to the output width. When the output is as wide as both inputs together, the exact product is passed on unchanged. Otherwise the low bits are discarded. The block either floors the result or rounds it to the nearest value, and the choice is made by a parameter. In rounding mode, an exact half-LSB case is settled by a one-bit dither input. Feeding that input a random bit removes rounding bias.

The pipeline cannot be stalled. The output has no ready signal, and a result appears a fixed number of cycles after its operands are accepted. There is one clock and one active-low reset, synchronous to that clock. All three data widths must be multiples of 8. The extra pipeline depth `EXTRA_STAGES` must be at least 2.

Top module: `cmul_stream_mul`

## Requirements
- R1: `a_tready` and `b_tready` are low while `aresetn` is low and during the first cycle after it is released. After that they stay high.
- R2: An operand pair is accepted only on a rising edge where `a_tvalid` and `b_tvalid` are both high (and the ready signals are high). If only one valid is high, no output is ever produced.
- R3: For each accepted pair, `p_tvalid` is high for exactly one cycle. That cycle follows the rising edge that comes `EXTRA_STAGES + 2` edges after the accepting edge. Pairs accepted on consecutive edges produce results on consecutive cycles. A cycle with no result has `p_tvalid` low.
- R4: The lower half of every tdata word is the real part and the upper half is the imaginary part. Both parts are signed two's complement, and this holds for both inputs and the output.
- R5: The real result is ar·br − ai·bi and the imaginary result is ar·bi + ai·br, both formed without loss. When `OUT_W == A_W + B_W`, each output part equals that exact value modulo 2^(OUT_W/2).
- R6: In floor mode (`RND_MODE = RND_FLOOR`, encoding 0), each part is the exact value shifted right arithmetically by S = (A_W + B_W − OUT_W)/2 bits. This is rounding toward minus infinity, and the result wraps modulo 2^(OUT_W/2).
- R7: In nearest mode (`RND_MODE = RND_NEAREST`, encoding 1), a value whose discarded fraction is not exactly one half goes to the nearer output value. The result wraps modulo 2^(OUT_W/2).
- R8: In nearest mode, an exact half is handled by `tie_bit`, which is sampled on the accepting edge. With `tie_bit` at 0 the value moves away from zero. With `tie_bit` at 1 it moves toward zero.
- R9: Reset discards every product that is in flight. `p_tvalid` is low during reset and stays low after it until a new pair has been accepted and has passed through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aresetn | input | 1 | Synchronous reset, active low |
| tie_bit | input | 1 | Tie-break (dither) bit for exact halves, sampled with the operands |
| a_tvalid | input | 1 | Operand A valid |
| a_tready | output | 1 | Operand A ready |
| a_tdata | input | A_W | Operand A: imaginary part in the upper half, real part in the lower half |
| b_tvalid | input | 1 | Operand B valid |
| b_tready | output | 1 | Operand B ready |
| b_tdata | input | B_W | Operand B: imaginary part in the upper half, real part in the lower half |
| p_tvalid | output | 1 | Product valid |
| p_tdata | output | OUT_W | Product: imaginary part in the upper half, real part in the lower half |

## Verification
A result is due in the cycle after the edge that comes `EXTRA_STAGES + 2` edges after the edge that accepted its operands. With the default depth this is five register stages: products, sums, two delay stages and the output stage. The driver stamps every expected result with that due cycle, counted from a free-running edge counter, when it offers a pair. The monitor compares only in the cycle the result is due. A result that is early, late, missing or unexpected is a timing miscompare, separate from a data miscompare. Three instances share the same stimulus: one in nearest mode, one in floor mode and one at full width. This way rounding, flooring and the exact pass-through are all checked on the same operands.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic {
        RND_FLOOR   = 1'b0,
        RND_NEAREST = 1'b1
    } rnd_mode_e;

endpackage

// File: rtl/cmul_mult.sv
module cmul_mult #(
    parameter int AH = 8,
    parameter int BH = 8
) (
    input  logic                 clk,
    input  logic                 aresetn,
    input  logic                 launch,
    input  logic                 tie_in,
    input  logic signed [AH-1:0] ar,
    input  logic signed [AH-1:0] ai,
    input  logic signed [BH-1:0] br,
    input  logic signed [BH-1:0] bi,
    output logic                 sum_vld,
    output logic                 sum_tie,
    output logic signed [AH+BH:0] sum_re,
    output logic signed [AH+BH:0] sum_im
);

    localparam int PW = AH + BH;
    localparam int FW = PW + 1;

    typedef struct packed {
        logic                 p_vld;
        logic                 p_tie;
        logic signed [PW-1:0] rr;
        logic signed [PW-1:0] ii;
        logic signed [PW-1:0] ri;
        logic signed [PW-1:0] ir;
        logic                 s_vld;
        logic                 s_tie;
        logic signed [FW-1:0] re;
        logic signed [FW-1:0] im;
    } mult_st_t;

    mult_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.p_vld = launch;
        st_d.p_tie = tie_in;
        if (launch) begin
            st_d.rr = PW'(ar) * PW'(br);
            st_d.ii = PW'(ai) * PW'(bi);
            st_d.ri = PW'(ar) * PW'(bi);
            st_d.ir = PW'(ai) * PW'(br);
        end
        st_d.s_vld = st_q.p_vld;
        st_d.s_tie = st_q.p_tie;
        st_d.re    = FW'(st_q.rr) - FW'(st_q.ii);
        st_d.im    = FW'(st_q.ri) + FW'(st_q.ir);
    end

    always_ff @(posedge clk) begin
        if (!aresetn) st_q <= '0;
        else          st_q <= st_d;
    end

    assign sum_vld = st_q.s_vld;
    assign sum_tie = st_q.s_tie;
    assign sum_re  = st_q.re;
    assign sum_im  = st_q.im;

    // R3: an accepted pair yields summed parts two edges later
    a_r3_sum_after_launch: assert property (@(posedge clk) disable iff (!aresetn)
        launch |=> ##1 sum_vld);

    // R3: summed parts only exist for an earlier launch
    a_r3_sum_needs_launch: assert property (@(posedge clk) disable iff (!aresetn)
        sum_vld |-> $past(launch, 2));

endmodule

// File: rtl/cmul_delay.sv
module cmul_delay #(
    parameter int W     = 35,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         aresetn,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign out_vld = in_vld;
            assign out_dat = in_dat;
        end else begin : g_pipe
            logic [DEPTH-1:0] vld_d, vld_q;
            logic [W-1:0]     dat_d [DEPTH];
            logic [W-1:0]     dat_q [DEPTH];

            always_comb begin
                vld_d[0] = in_vld;
                dat_d[0] = in_dat;
                for (int i = 1; i < DEPTH; i++) begin
                    vld_d[i] = vld_q[i-1];
                    dat_d[i] = dat_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!aresetn) begin
                    vld_q <= '0;
                    for (int i = 0; i < DEPTH; i++) dat_q[i] <= '0;
                end else begin
                    vld_q <= vld_d;
                    for (int i = 0; i < DEPTH; i++) dat_q[i] <= dat_d[i];
                end
            end

            assign out_vld = vld_q[DEPTH-1];
            assign out_dat = dat_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/cmul_reduce.sv
module cmul_reduce
    import cmul_pkg::*;
#(
    parameter int        FW   = 17,
    parameter int        OW   = 8,
    parameter rnd_mode_e MODE = RND_NEAREST
) (
    input  logic                 clk,
    input  logic                 aresetn,
    input  logic                 in_vld,
    input  logic                 in_tie,
    input  logic signed [FW-1:0] in_re,
    input  logic signed [FW-1:0] in_im,
    output logic                 out_vld,
    output logic [OW-1:0]        out_re,
    output logic [OW-1:0]        out_im
);

    localparam int SH = FW - 1 - OW;

    typedef struct packed {
        logic          vld;
        logic [OW-1:0] re;
        logic [OW-1:0] im;
    } red_st_t;

    red_st_t st_d, st_q;

    generate
        if (SH == 0) begin : g_exact
            always_comb begin
                st_d.vld = in_vld;
                st_d.re  = in_re[OW-1:0];
                st_d.im  = in_im[OW-1:0];
            end
        end else begin : g_shrink
            function automatic logic [OW-1:0] shrink(logic [FW-1:0] v, logic tie);
                logic [OW-1:0] fl;
                logic [SH-1:0] fr;
                logic          at_half;
                logic          bump;
                fl      = v[SH+OW-1:SH];
                fr      = v[SH-1:0];
                at_half = (fr == (SH'(1) << (SH - 1)));
                bump    = 1'b0;
                if (MODE == RND_NEAREST)
                    bump = (fr[SH-1] && !at_half) || (at_half && (v[FW-1] ^ !tie));
                return fl + OW'(bump);
            endfunction

            always_comb begin
                st_d.vld = in_vld;
                st_d.re  = shrink(in_re, in_tie);
                st_d.im  = shrink(in_im, in_tie);
            end

            // R7: the kept part never moves more than one step above the floor
            a_r7_step_at_most_one: assert property (@(posedge clk) disable iff (!aresetn)
                in_vld |=> (OW'(out_re - $past(in_re[SH+OW-1:SH])) <= OW'(1)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!aresetn) st_q <= '0;
        else          st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_re  = st_q.re;
    assign out_im  = st_q.im;

endmodule

// File: rtl/cmul_stream_mul.sv
module cmul_stream_mul
    import cmul_pkg::*;
#(
    parameter int        A_W          = 16,
    parameter int        B_W          = 16,
    parameter int        OUT_W        = 16,
    parameter int        EXTRA_STAGES = 2,
    parameter rnd_mode_e RND_MODE     = RND_NEAREST
) (
    input  logic             clk,
    input  logic             aresetn,
    input  logic             tie_bit,
    input  logic             a_tvalid,
    output logic             a_tready,
    input  logic [A_W-1:0]   a_tdata,
    input  logic             b_tvalid,
    output logic             b_tready,
    input  logic [B_W-1:0]   b_tdata,
    output logic             p_tvalid,
    output logic [OUT_W-1:0] p_tdata
);

    localparam int AH = A_W / 2;
    localparam int BH = B_W / 2;
    localparam int OH = OUT_W / 2;
    localparam int FW = AH + BH + 1;
    localparam int DW = 2 * FW + 1;

    logic rdy_d, rdy_q;

    always_comb rdy_d = 1'b1;

    always_ff @(posedge clk) begin
        if (!aresetn) rdy_q <= 1'b0;
        else          rdy_q <= rdy_d;
    end

    assign a_tready = rdy_q;
    assign b_tready = rdy_q;

    logic launch;
    assign launch = a_tvalid && b_tvalid && rdy_q;

    logic                 sum_vld, sum_tie;
    logic signed [FW-1:0] sum_re, sum_im;

    cmul_mult #(.AH(AH), .BH(BH)) u_mult (
        .clk     (clk),
        .aresetn (aresetn),
        .launch  (launch),
        .tie_in  (tie_bit),
        .ar      (a_tdata[AH-1:0]),
        .ai      (a_tdata[A_W-1:AH]),
        .br      (b_tdata[BH-1:0]),
        .bi      (b_tdata[B_W-1:BH]),
        .sum_vld (sum_vld),
        .sum_tie (sum_tie),
        .sum_re  (sum_re),
        .sum_im  (sum_im)
    );

    logic          dly_vld;
    logic [DW-1:0] dly_dat;

    cmul_delay #(.W(DW), .DEPTH(EXTRA_STAGES)) u_delay (
        .clk     (clk),
        .aresetn (aresetn),
        .in_vld  (sum_vld),
        .in_dat  ({sum_tie, sum_re, sum_im}),
        .out_vld (dly_vld),
        .out_dat (dly_dat)
    );

    logic [OH-1:0] res_re, res_im;

    cmul_reduce #(.FW(FW), .OW(OH), .MODE(RND_MODE)) u_reduce (
        .clk     (clk),
        .aresetn (aresetn),
        .in_vld  (dly_vld),
        .in_tie  (dly_dat[DW-1]),
        .in_re   (dly_dat[DW-2:FW]),
        .in_im   (dly_dat[FW-1:0]),
        .out_vld (p_tvalid),
        .out_re  (res_re),
        .out_im  (res_im)
    );

    assign p_tdata = {res_im, res_re};

    // R1: both inputs accept once a cycle has passed out of reset
    a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!aresetn)
        $past(aresetn) |-> (a_tready && b_tready));

    // R9: nothing emerges in the first cycle after reset
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!aresetn)
        !$past(aresetn) |-> !p_tvalid);

endmodule

// File: tb/cmul_stream_mul_tb.sv
`timescale 1ns/1ps
module cmul_stream_mul_tb;
    import cmul_pkg::*;

    localparam int E   = 2;
    localparam int LAT = E + 3;

    typedef struct {
        int          due;
        logic [31:0] dat;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        aresetn = 1'b0;
    logic        tie_bit = 1'b0;
    logic        a_tvalid = 1'b0, b_tvalid = 1'b0;
    logic [15:0] a_tdata = '0, b_tdata = '0;
    logic        ar0, br0, ar1, br1, ar2, br2;
    logic        v0, v1, v2;
    logic [15:0] d0, d1;
    logic [31:0] d2;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int spurious = 0;
    exp_t q0[$], q1[$], q2[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmul_stream_mul #(.A_W(16), .B_W(16), .OUT_W(16), .EXTRA_STAGES(E), .RND_MODE(RND_NEAREST)) u_dut (
        .clk(clk), .aresetn(aresetn), .tie_bit(tie_bit),
        .a_tvalid(a_tvalid), .a_tready(ar0), .a_tdata(a_tdata),
        .b_tvalid(b_tvalid), .b_tready(br0), .b_tdata(b_tdata),
        .p_tvalid(v0), .p_tdata(d0));

    cmul_stream_mul #(.A_W(16), .B_W(16), .OUT_W(16), .EXTRA_STAGES(E), .RND_MODE(RND_FLOOR)) u_dut_trunc (
        .clk(clk), .aresetn(aresetn), .tie_bit(tie_bit),
        .a_tvalid(a_tvalid), .a_tready(ar1), .a_tdata(a_tdata),
        .b_tvalid(b_tvalid), .b_tready(br1), .b_tdata(b_tdata),
        .p_tvalid(v1), .p_tdata(d1));

    cmul_stream_mul #(.A_W(16), .B_W(16), .OUT_W(32), .EXTRA_STAGES(E), .RND_MODE(RND_NEAREST)) u_dut_full (
        .clk(clk), .aresetn(aresetn), .tie_bit(tie_bit),
        .a_tvalid(a_tvalid), .a_tready(ar2), .a_tdata(a_tdata),
        .b_tvalid(b_tvalid), .b_tready(br2), .b_tdata(b_tdata),
        .p_tvalid(v2), .p_tdata(d2));

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic longint reduce(longint full, int sh, bit nearest, bit tie);
        longint fl, rem, half;
        fl  = full >>> sh;
        rem = full - (fl <<< sh);
        if (sh > 0 && nearest) begin
            half = 64'sd1 <<< (sh - 1);
            if (rem > half) fl++;
            else if (rem == half) begin
                if (full >= 0) begin
                    if (!tie) fl++;
                end else begin
                    if (tie) fl++;
                end
            end
        end
        return fl;
    endfunction

    function automatic logic [31:0] model(int ar, int ai, int br, int bi,
                                          int sh, bit nearest, bit tie);
        longint re, im, r, i;
        logic [63:0] ru, iu;
        re = longint'(ar * br - ai * bi);
        im = longint'(ar * bi + ai * br);
        r  = reduce(re, sh, nearest, tie);
        i  = reduce(im, sh, nearest, tie);
        ru = r;
        iu = i;
        if (sh > 0) return {16'h0, iu[7:0], ru[7:0]};
        return {iu[15:0], ru[15:0]};
    endfunction

    task automatic mon(ref exp_t q[$], input logic v, input logic [31:0] d, input string who);
        exp_t e;
        while (q.size() > 0 && q[0].due < cyc) begin
            e = q.pop_front();
            chk(1'b0, "R3", {who, " result missing"}, 0, 1);
        end
        if (v) begin
            if (q.size() == 0 || q[0].due != cyc) begin
                spurious++;
                chk(1'b0, "R3", {who, " unexpected p_tvalid"}, 1, 0);
            end else begin
                e = q.pop_front();
                chk(d === e.dat, e.tag, {who, " data"}, d, e.dat);
            end
        end
    endtask

    always @(negedge clk) begin
        if (aresetn) begin
            mon(q0, v0, {16'h0, d0}, "nearest");
            mon(q1, v1, {16'h0, d1}, "floor");
            mon(q2, v2, d2, "full");
        end
    end

    task automatic drive(input int ar, input int ai, input int br, input int bi,
                         input bit av, input bit bv, input bit tb, input string tie_tag);
        exp_t e;
        @(negedge clk);
        a_tdata  = {8'(ai), 8'(ar)};
        b_tdata  = {8'(bi), 8'(br)};
        a_tvalid = av;
        b_tvalid = bv;
        tie_bit  = tb;
        if (av && bv) begin
            e.due = cyc + LAT;
            e.dat = model(ar, ai, br, bi, 8, 1'b1, tb);
            e.tag = (tie_tag != "") ? tie_tag : "R7";
            q0.push_back(e);
            e.dat = model(ar, ai, br, bi, 8, 1'b0, tb);
            e.tag = "R6";
            q1.push_back(e);
            e.dat = model(ar, ai, br, bi, 0, 1'b1, tb);
            e.tag = "R4/R5";
            q2.push_back(e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 1'b0, 1'b0, 1'b0, "");
    endtask

    function automatic int s8();
        logic [7:0] t;
        t = 8'($urandom);
        return int'($signed(t));
    endfunction

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        // reset state: R1, R9
        repeat (3) @(negedge clk);
        chk(!v0 && !v1 && !v2, "R9", "p_tvalid in reset", {v0, v1, v2}, 0);
        chk(!ar0 && !br0, "R1", "ready in reset", {ar0, br0}, 0);
        @(negedge clk) aresetn = 1'b1;
        @(negedge clk);
        chk(ar0 && br0 && ar1 && br2, "R1", "ready after reset", {ar0, br0}, 3);

        // directed products: R4, R5, R6, R7
        drive(1, 0, 1, 0, 1, 1, 0, "");
        drive(3, 4, 5, 6, 1, 1, 0, "");
        drive(-128, -128, -128, -128, 1, 1, 0, "");
        drive(1, 0, 127, 0, 1, 1, 0, "");
        drive(3, 0, 43, 0, 1, 1, 0, "");
        drive(-3, 0, 43, 0, 1, 1, 0, "");
        drive(-1, 0, 127, 0, 1, 1, 0, "");
        // exact halves: R8
        drive(6, 0, 64, 0, 1, 1, 0, "R8");
        drive(6, 0, 64, 0, 1, 1, 1, "R8");
        drive(-6, 0, 64, 0, 1, 1, 0, "R8");
        drive(-6, 0, 64, 0, 1, 1, 1, "R8");
        drive(0, 6, 64, 0, 1, 1, 0, "R8");
        drive(0, -6, 64, 0, 1, 1, 1, "R8");
        idle(LAT + 2);

        // random stream with gaps and lone valids: R2, R3, R7
        for (int i = 0; i < 300; i++)
            drive(s8(), s8(), s8(), s8(), ($urandom % 4) != 0, ($urandom % 4) != 0,
                  1'($urandom), "");
        idle(LAT + 2);

        // lone valids never launch: R2
        base = spurious;
        for (int i = 0; i < 8; i++) drive(5, 5, 5, 5, 1, 0, 0, "");
        for (int i = 0; i < 8; i++) drive(5, 5, 5, 5, 0, 1, 0, "");
        idle(LAT + 2);
        chk(spurious == base, "R2", "outputs from lone valid", spurious - base, 0);

        // reset with products in flight: R9
        drive(7, 7, 7, 7, 1, 1, 0, "");
        drive(9, 9, 9, 9, 1, 1, 0, "");
        @(negedge clk);
        a_tvalid = 1'b0;
        b_tvalid = 1'b0;
        aresetn  = 1'b0;
        q0.delete();
        q1.delete();
        q2.delete();
        base = spurious;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!v0 && !v1 && !v2, "R9", "p_tvalid during reset", {v0, v1, v2}, 0);
        end
        aresetn = 1'b1;
        idle(LAT + 3);
        chk(spurious == base, "R9", "flushed products reappeared", spurious - base, 0);

        chk(q0.size() + q1.size() + q2.size() == 0, "R3", "results outstanding",
            q0.size() + q1.size() + q2.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule